// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the device-side controller of a byte-wide parallel flash memory. It sits on the bus where write and read cycles arrive as single-cycle strobes. The host reaches every function only by writing fixed unlock patterns to two magic addresses, followed by a command byte. The recognised commands are:

- return to read mode
- identifier readout
- byte program
- whole-chip erase
- single-sector erase

Once a program or erase sequence completes, an embedded engine runs the operation on a small on-chip byte array. The operation takes a number of clock cycles set by parameters.

No ready pin is provided. The host learns progress by reading. While an operation runs, bit 7 of any read carries the inverse of the final value expected at the target, and bit 6 flips on each read. When the operation finishes, true data returns and bit 6 holds still. Any write that does not fit the expected sequence drops the decoder back to read mode. Writes that arrive while the engine is busy are discarded.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the whole array holds FFH and the decoder is in read mode; a read strobe returns the addressed byte on `rdata` in the following cycle.
- R2: A command is accepted only after two unlock writes, AAH to address 5555H and then 55H to address 2AAAH, followed by the command byte written to 5555H; addresses are compared on the low 15 bits.
- R3: Writing F0H leaves identifier mode and returns to read mode, either as one write to any address or as the command byte of a full unlock sequence.
- R4: Command 90H enters identifier mode: array offset 00H reads `MFR_CODE` (default 40H), offset 01H reads the device code (A1H when `BOTTOM_BOOT`=1, else 01H), and every other offset reads 00H.
- R5: Command A0H arms a byte program; the next write programs its address with the AND of the old byte and the written data.
- R6: The six-write sequence ending in 10H to 5555H first writes 00H to every byte in address order, then erases the sectors one after another, so the whole array ends at FFH.
- R7: The six-write sequence ending in 30H erases only the sector holding the written address (sector = top log2(`SECTORS`) array address bits) to FFH; other sectors keep their contents.
- R8: While an operation runs, read bit 7 is the inverse of the target's final bit 7 (the programmed data for a program, 1 for an erase), and bits 5:0 show the array byte as it stands.
- R9: Bit 6 inverts on every read made while busy; after the operation the reads return true data and bit 6 no longer changes.
- R10: A write that breaks an expected sequence step returns the decoder to read mode (leaving identifier mode) without altering the array.
- R11: Writes received while an operation runs are ignored: they start no command and change no byte.
- R12: A byte program stays busy for exactly `PROG_CYC` cycles: a read strobed `PROG_CYC` cycles after the data write still reports busy, and one strobed a cycle later returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| rd_en | input | 1 | One-cycle bus read strobe |
| addr | input | ADDR_W | Bus address for the current cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |

## Verification
A corrupt sequence state shows up as one of two wrong reads. Either a later program or erase fails to change the array, or identifier codes appear where array data belongs. Both show on the first read after the sequence. A wrong engine state is seen at the ports through the polling bits. Bit 7 keeps the wrong sense, bit 6 stops flipping, or busy ends a cycle early or late. The exact-window read around `PROG_CYC` catches that within one cycle. Misdirected erase or fill pointers show up as changed bytes in sectors that should be untouched. Bytes caught mid-erase that still show their old low bits reveal the same fault.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam logic [14:0] MAGIC_LO  = 15'h5555;
    localparam logic [14:0] MAGIC_HI  = 15'h2AAA;
    localparam logic [7:0]  KEY_FIRST = 8'hAA;
    localparam logic [7:0]  KEY_SECOND = 8'h55;
    localparam logic [7:0]  CMD_RESET = 8'hF0;
    localparam logic [7:0]  CMD_IDENT = 8'h90;
    localparam logic [7:0]  CMD_PROG  = 8'hA0;
    localparam logic [7:0]  CMD_ESETUP = 8'h80;
    localparam logic [7:0]  CMD_CHIP  = 8'h10;
    localparam logic [7:0]  CMD_SECT  = 8'h30;
    localparam logic [7:0]  ERASED    = 8'hFF;

    typedef enum logic [2:0] {
        SQ_READ, SQ_KEY1, SQ_KEY2, SQ_PARM, SQ_ESET, SQ_EKEY1, SQ_EKEY2
    } seq_state_e;

    typedef enum logic [1:0] {OP_PROG, OP_CHIP, OP_SECT} op_e;

    typedef enum logic [2:0] {
        EN_IDLE, EN_PROG, EN_ZERO, EN_WAIT, EN_FILL
    } eng_state_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] data;
    } op_req_t;

    function automatic logic addr_is(input logic [14:0] a, input logic [14:0] target);
        return a == target;
    endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [14:0]       addr,
    input  logic [7:0]        wdata,
    output logic              start,
    output op_req_t           req,
    output logic [MEM_AW-1:0] req_addr,
    output logic              id_mode
);

    seq_state_e st, st_n;
    logic       id_n;
    logic       at_lo, at_hi;

    assign at_lo    = addr_is(addr, MAGIC_LO);
    assign at_hi    = addr_is(addr, MAGIC_HI);
    assign req_addr = addr[MEM_AW-1:0];

    always_comb begin
        st_n     = st;
        id_n     = id_mode;
        start    = 1'b0;
        req.op   = OP_PROG;
        req.data = wdata;
        if (wr) begin
            st_n = SQ_READ;
            id_n = 1'b0;
            unique case (st)
                SQ_READ: if (at_lo && wdata == KEY_FIRST) begin
                    st_n = SQ_KEY1;
                    id_n = id_mode;
                end
                SQ_KEY1: if (at_hi && wdata == KEY_SECOND) begin
                    st_n = SQ_KEY2;
                    id_n = id_mode;
                end
                SQ_KEY2: if (at_lo) begin
                    if (wdata == CMD_IDENT)       id_n = 1'b1;
                    else if (wdata == CMD_PROG)   st_n = SQ_PARM;
                    else if (wdata == CMD_ESETUP) st_n = SQ_ESET;
                end
                SQ_PARM: start = 1'b1;
                SQ_ESET: if (at_lo && wdata == KEY_FIRST) st_n = SQ_EKEY1;
                SQ_EKEY1: if (at_hi && wdata == KEY_SECOND) st_n = SQ_EKEY2;
                SQ_EKEY2: begin
                    if (at_lo && wdata == CMD_CHIP) begin
                        start  = 1'b1;
                        req.op = OP_CHIP;
                    end else if (wdata == CMD_SECT) begin
                        start  = 1'b1;
                        req.op = OP_SECT;
                    end
                end
                default: st_n = SQ_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_READ;
            id_mode <= 1'b0;
        end else begin
            st      <= st_n;
            id_mode <= id_n;
        end
    end

    // R3: a reset byte written from read mode always leaves identifier mode
    p_id_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata == CMD_RESET && st == SQ_READ) |=> !id_mode);

endmodule

// File: rtl/fcd_engine.sv
module fcd_engine
    import fcd_pkg::*;
#(
    parameter int MEM_AW    = 8,
    parameter int SECTORS   = 4,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_req_t           req,
    input  logic [MEM_AW-1:0] req_addr,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    output logic              busy,
    output logic              poll7
);

    localparam int DEPTH  = 1 << MEM_AW;
    localparam int SECT_W = $clog2(SECTORS);
    localparam int OFF_W  = MEM_AW - SECT_W;
    localparam int MAXC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);

    logic [7:0]        mem [DEPTH];
    eng_state_e        st;
    op_e               op_q;
    logic [7:0]        dat_q;
    logic [MEM_AW-1:0] ptr;
    logic [SECT_W-1:0] sect;
    logic [CNT_W-1:0]  cnt;

    assign busy    = (st != EN_IDLE);
    assign rd_byte = mem[rd_addr];
    assign poll7   = (op_q == OP_PROG) ? dat_q[7] : ERASED[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= EN_IDLE;
            op_q  <= OP_PROG;
            dat_q <= '0;
            ptr   <= '0;
            sect  <= '0;
            cnt   <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else begin
            unique case (st)
                EN_IDLE: if (start) begin
                    op_q  <= req.op;
                    dat_q <= req.data;
                    unique case (req.op)
                        OP_PROG: begin
                            st  <= EN_PROG;
                            ptr <= req_addr;
                            cnt <= CNT_W'(PROG_CYC - 1);
                        end
                        OP_CHIP: begin
                            st  <= EN_ZERO;
                            ptr <= '0;
                        end
                        default: begin
                            st   <= EN_WAIT;
                            sect <= req_addr[MEM_AW-1 -: SECT_W];
                            cnt  <= CNT_W'(ERASE_CYC - 1);
                        end
                    endcase
                end
                EN_PROG: begin
                    if (cnt == '0) begin
                        mem[ptr] <= mem[ptr] & dat_q;
                        st       <= EN_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                EN_ZERO: begin
                    mem[ptr] <= 8'h00;
                    ptr      <= ptr + 1'b1;
                    if (ptr == MEM_AW'(DEPTH - 1)) begin
                        st   <= EN_WAIT;
                        sect <= '0;
                        cnt  <= CNT_W'(ERASE_CYC - 1);
                    end
                end
                EN_WAIT: begin
                    if (cnt == '0) begin
                        st  <= EN_FILL;
                        ptr <= {sect, {OFF_W{1'b0}}};
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                EN_FILL: begin
                    mem[ptr] <= ERASED;
                    ptr      <= ptr + 1'b1;
                    if (&ptr[OFF_W-1:0]) begin
                        if (op_q == OP_CHIP && sect != SECT_W'(SECTORS - 1)) begin
                            sect <= sect + 1'b1;
                            st   <= EN_WAIT;
                            cnt  <= CNT_W'(ERASE_CYC - 1);
                        end else begin
                            st <= EN_IDLE;
                        end
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    // R11: the decoder never launches an operation on a running engine
    p_start_idle_r11: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R5: busy is entered only in response to a launched operation
    p_busy_src_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R7: the erase fill pointer stays inside the sector being erased
    p_fill_sector_r7: assert property (@(posedge clk) disable iff (rst)
        (st == EN_FILL) |-> (ptr[MEM_AW-1 -: SECT_W] == sect));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W      = 15,
    parameter int         MEM_AW      = 8,
    parameter int         SECTORS     = 4,
    parameter int         PROG_CYC    = 8,
    parameter int         ERASE_CYC   = 16,
    parameter logic [7:0] MFR_CODE    = 8'h40,
    parameter bit         BOTTOM_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam logic [7:0] DEV_CODE = BOTTOM_BOOT ? 8'hA1 : 8'h01;

    logic              busy, poll7, id_mode, start, tog;
    op_req_t           req;
    logic [MEM_AW-1:0] req_addr, off;
    logic [7:0]        arr_byte, id_byte;

    assign off = addr[MEM_AW-1:0];

    fcd_seq #(.MEM_AW(MEM_AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_en && !busy),
        .addr     (addr[14:0]),
        .wdata    (wdata),
        .start    (start),
        .req      (req),
        .req_addr (req_addr),
        .id_mode  (id_mode)
    );

    fcd_engine #(
        .MEM_AW    (MEM_AW),
        .SECTORS   (SECTORS),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req      (req),
        .req_addr (req_addr),
        .rd_addr  (off),
        .rd_byte  (arr_byte),
        .busy     (busy),
        .poll7    (poll7)
    );

    always_comb begin
        if (off == '0)                    id_byte = MFR_CODE;
        else if (off == MEM_AW'(1))       id_byte = DEV_CODE;
        else                              id_byte = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            tog   <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rdata <= {~poll7, tog, arr_byte[5:0]};
                tog   <= ~tog;
            end else if (id_mode) begin
                rdata <= id_byte;
            end else begin
                rdata <= arr_byte;
            end
        end
    end

    // R9: back-to-back busy reads report opposite values on bit 6
    p_toggle_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) ##1 (rd_en && busy) |=> (rdata[6] != $past(rdata[6])));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    localparam int PC = 8;
    localparam int EC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [7:0] val;
        logic [7:0] mask;
        bit         tgl;
        string      tag;
    } exp_t;

    exp_t        q[$];
    logic        rd_d = 1'b0;
    logic [7:0]  last_rd = '0;

    always #5 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    always @(posedge clk) rd_d <= rd_en;

    // monitor: pops the expected item and compares one half cycle after the read edge
    always @(negedge clk) begin
        if (rd_d) begin
            n_tests++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL monitor: unexpected read data %02h, expected nothing", rdata);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.tgl) begin
                    if (rdata[6] == last_rd[6]) begin
                        n_fail++;
                        $display("FAIL %s: bit6 actual %0b expected %0b", e.tag, rdata[6], ~last_rd[6]);
                    end
                end else if ((rdata & e.mask) != (e.val & e.mask)) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h (mask %02h)",
                             e.tag, rdata & e.mask, e.val & e.mask, e.mask);
                end
            end
            last_rd = rdata;
        end
    end

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, input logic [7:0] v,
                      input logic [7:0] m, input bit t, input string tag);
        exp_t e;
        e.val = v; e.mask = m; e.tgl = t; e.tag = tag;
        q.push_back(e);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: erased after reset
        rd(15'h0010, 8'hFF, 8'hFF, 0, "R1 reset 10h");
        rd(15'h00C0, 8'hFF, 8'hFF, 0, "R1 reset C0h");

        // R2 R5: program 10h with 5Ah, then poll during busy
        unlock(); wr(15'h5555, 8'hA0); wr(15'h0010, 8'h5A);
        rd(15'h0010, 8'h80, 8'h80, 0, "R8 poll bit7 program");
        rd(15'h0010, 8'h00, 8'h00, 1, "R9 toggle while busy");
        // R11: a full program sequence while busy must be ignored
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
        wr(15'h5555, 8'hA0); wr(15'h0020, 8'h00);
        idle(PC + 2);
        rd(15'h0010, 8'h5A, 8'hFF, 0, "R5 programmed byte");
        rd(15'h0010, 8'h5A, 8'hFF, 0, "R9 stable after done");
        rd(15'h0020, 8'hFF, 8'hFF, 0, "R11 write during busy ignored");

        // R5: programming only clears bits
        unlock(); wr(15'h5555, 8'hA0); wr(15'h0010, 8'h0F);
        idle(PC + 2);
        rd(15'h0010, 8'h0A, 8'hFF, 0, "R5 AND with old data");

        // R12: exact busy window
        unlock(); wr(15'h5555, 8'hA0); wr(15'h0030, 8'h00);
        idle(PC - 1);
        rd(15'h0030, 8'h80, 8'h80, 0, "R12 still busy at last cycle");
        rd(15'h0030, 8'h00, 8'hFF, 0, "R12 done one cycle later");

        // R4: identifier mode
        unlock(); wr(15'h5555, 8'h90);
        rd(15'h0000, 8'h40, 8'hFF, 0, "R4 manufacturer code");
        rd(15'h0001, 8'hA1, 8'hFF, 0, "R4 device code");
        rd(15'h0002, 8'h00, 8'hFF, 0, "R4 other offset");
        // R3: single-cycle reset at any address
        wr(15'h1234, 8'hF0);
        rd(15'h0000, 8'hFF, 8'hFF, 0, "R3 single-cycle reset");
        // R3: full-sequence reset
        unlock(); wr(15'h5555, 8'h90);
        unlock(); wr(15'h5555, 8'hF0);
        rd(15'h0001, 8'hFF, 8'hFF, 0, "R3 sequence reset");

        // R10: wrong command address aborts, the following write programs nothing
        unlock(); wr(15'h1234, 8'hA0); wr(15'h0040, 8'h00);
        rd(15'h0040, 8'hFF, 8'hFF, 0, "R10 aborted program");
        // R10: broken step leaves identifier mode
        unlock(); wr(15'h5555, 8'h90);
        wr(15'h1111, 8'hAA);
        rd(15'h0000, 8'hFF, 8'hFF, 0, "R10 abort leaves id mode");
        // R2: wrong second key aborts
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h12); wr(15'h5555, 8'hA0); wr(15'h0041, 8'h00);
        rd(15'h0041, 8'hFF, 8'hFF, 0, "R2 bad key rejected");

        // R7: sector erase of sector 1 (40h..7Fh)
        unlock(); wr(15'h5555, 8'hA0); wr(15'h0050, 8'h11); idle(PC + 2);
        unlock(); wr(15'h5555, 8'hA0); wr(15'h0090, 8'h22); idle(PC + 2);
        unlock(); wr(15'h5555, 8'h80); unlock(); wr(15'h0045, 8'h30);
        rd(15'h0050, 8'h00, 8'h80, 0, "R8 poll bit7 erase");
        idle(EC + 80);
        rd(15'h0050, 8'hFF, 8'hFF, 0, "R7 sector erased");
        rd(15'h0090, 8'h22, 8'hFF, 0, "R7 other sector kept");
        rd(15'h0010, 8'h0A, 8'hFF, 0, "R7 sector 0 kept");

        // R6: chip erase, zero pass observed mid-way
        unlock(); wr(15'h5555, 8'h80); unlock(); wr(15'h5555, 8'h10);
        idle(198);
        rd(15'h0090, 8'h00, 8'hBF, 0, "R6 pre-zero pass");
        idle(700);
        rd(15'h0010, 8'hFF, 8'hFF, 0, "R6 chip erased 10h");
        rd(15'h0090, 8'hFF, 8'hFF, 0, "R6 chip erased 90h");
        rd(15'h0030, 8'hFF, 8'hFF, 0, "R6 chip erased 30h");
        rd(15'h00FF, 8'hFF, 8'hFF, 0, "R6 chip erased FFh");

        idle(4);
        if (q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL monitor: %0d reads unanswered, expected 0", q.size());
        end
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run still active, expected completion");
        summary();
        $finish;
    end

endmodule